// File: doc/BRIEF.md
# Per-Page Thread Sharing Tracker

This block keeps a small table that records, for every page, which thread has touched it and whether the page is still private, read-only shared or shared for writing. Each access request carries a page index, the requesting thread, a read/write flag and the write permission that the page tables allow. The block updates the page record and answers one cycle later. The answer carries a response code, a "safe" flag (the access needs no memory-ordering enforcement) and the write permission to install in the translation entry.

A page moves into the shared read-write state only after a remote invalidation. The block sends an invalidate to the owning thread's core, or broadcasts it when the page is shared read-only. It holds that page locked until the acknowledge returns, and then reports completion on a separate output. A clear input returns every page to the untouched state. It is meant for the moment a second thread is created.

Top module: `page_share_tracker`

## Requirements
- R1: After reset no response, invalidate or completion is raised, and every page is untouched.
- R2: A read of an untouched page by thread T (T not all-ones) makes T the owner of a private read-only page and answers OK with safe=1 and write permission 0, even when the page is writable.
- R3: A permitted write to an untouched page makes the writer the owner of a private read-write page and answers OK with safe=1 and write permission 1.
- R4: A permitted write by the owner to its private read-only page makes it private read-write with OK, safe=1 and write permission 1. Later owner reads return safe=1 with the write permission equal to the page's permission input.
- R5: A permitted write by a non-owner to a private page answers WAIT with safe=0 and permission 0. It raises inv_valid with inv_bcast=0 and inv_target equal to the owner thread, and holds both until inv_ack.
- R6: A permitted write to a shared read-only page answers WAIT and raises inv_valid with inv_bcast=1 and inv_target all-ones.
- R7: The cycle after inv_ack is seen with inv_valid high, inv_valid drops and cmp_valid pulses for one cycle with the page and requesting thread. After that, every access to the page answers OK with safe=0 and write permission equal to the permission input.
- R8: A read by a thread other than the owner of a private page makes it shared read-only. That read, and every later read by any thread, answers OK with safe=1 and permission 0.
- R9: A write whose permission input is 0 answers FAULT with safe=0 and permission 0, and leaves the page record unchanged.
- R10: A request to a page with a pending invalidation answers RETRY. So does a request that would need an invalidation while another one is outstanding. Neither changes any state.
- R11: tbl_clear returns every page to untouched and cancels a pending invalidation without a completion. A request in the same cycle answers RETRY.
- R12: Each request is answered by rsp_valid exactly one cycle later. The response codes are OK=0, RETRY=1, FAULT=2 and WAIT=3. RETRY, FAULT and WAIT always carry safe=0 and permission 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tbl_clear | input | 1 | Return all pages to untouched, cancel invalidation |
| req_valid | input | 1 | Access request present |
| req_page | input | PAGE_W | Page index of the request |
| req_tid | input | 4 | Requesting thread ID |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_wr_ok | input | 1 | Page-level write permission |
| rsp_valid | output | 1 | Response present (one cycle after request) |
| rsp_code | output | 2 | OK=0, RETRY=1, FAULT=2, WAIT=3 |
| rsp_safe | output | 1 | Access needs no ordering enforcement |
| rsp_wperm | output | 1 | Write permission to install |
| inv_valid | output | 1 | Invalidate outstanding |
| inv_bcast | output | 1 | Invalidate goes to all cores |
| inv_target | output | 4 | Owner thread for a unicast invalidate |
| inv_ack | input | 1 | Invalidate acknowledged |
| cmp_valid | output | 1 | Page entered shared read-write |
| cmp_page | output | PAGE_W | Page that completed the move |
| cmp_tid | output | 4 | Thread whose write caused the move |

## Verification
The assertions check several properties on every cycle: responses follow requests by exactly one cycle, and FAULT and RETRY never grant anything. An outstanding invalidate keeps its target steady until acknowledged. Completions come only after an acknowledge, and a clear leaves nothing outstanding. The state walk through private, shared read-only and shared read-write cannot be expressed as a property, and neither can the owner-versus-stranger decisions or the fact that a fault leaves the record untouched. Only the bench scenarios and its reference model, which follow the pages across many requests, can show those.

// File: rtl/pst_pkg.sv
package pst_pkg;

    parameter int TID_W = 4;

    typedef logic [TID_W-1:0] tid_t;
    localparam tid_t TID_NONE = '1;

    typedef struct packed {
        tid_t owner;
        logic ro;
        logic shared;
    } page_rec_t;

    localparam page_rec_t REC_FRESH  = '{owner: TID_NONE, ro: 1'b1, shared: 1'b0};
    localparam page_rec_t REC_SHR_RW = '{owner: TID_NONE, ro: 1'b0, shared: 1'b1};

    typedef enum logic [1:0] {
        RSP_OK    = 2'd0,
        RSP_RETRY = 2'd1,
        RSP_FAULT = 2'd2,
        RSP_WAIT  = 2'd3
    } rsp_code_e;

    typedef enum logic [2:0] {
        PG_UNTOUCHED,
        PG_PRIV_RO,
        PG_PRIV_RW,
        PG_SHR_RO,
        PG_SHR_RW
    } pg_state_e;

    typedef struct packed {
        rsp_code_e code;
        logic      safe;
        logic      wperm;
        logic      upd;
        page_rec_t nrec;
        logic      start;
        logic      bcast;
        tid_t      target;
    } decision_t;

    function automatic pg_state_e classify(input page_rec_t r);
        if (r.shared)
            return r.ro ? PG_SHR_RO : PG_SHR_RW;
        else if (!r.ro)
            return PG_PRIV_RW;
        else if (r.owner == TID_NONE)
            return PG_UNTOUCHED;
        else
            return PG_PRIV_RO;
    endfunction

endpackage

// File: rtl/pst_table.sv
module pst_table
    import pst_pkg::*;
#(
    parameter int NUM_PAGES = 16,
    localparam int PAGE_W = $clog2(NUM_PAGES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic [PAGE_W-1:0] rd_page,
    output page_rec_t         rd_rec,
    output logic              rd_busy,
    input  logic              upd_en,
    input  logic              lock_en,
    input  logic [PAGE_W-1:0] upd_page,
    input  page_rec_t         upd_rec,
    input  logic              done_en,
    input  logic [PAGE_W-1:0] done_page
);

    page_rec_t             recs [NUM_PAGES];
    logic [NUM_PAGES-1:0]  busy;

    for (genvar g = 0; g < NUM_PAGES; g++) begin : g_page
        always_ff @(posedge clk) begin
            if (rst || clr) begin
                recs[g] <= REC_FRESH;
                busy[g] <= 1'b0;
            end else if (done_en && done_page == PAGE_W'(g)) begin
                recs[g] <= REC_SHR_RW;
                busy[g] <= 1'b0;
            end else if (upd_page == PAGE_W'(g)) begin
                if (upd_en)
                    recs[g] <= upd_rec;
                if (lock_en)
                    busy[g] <= 1'b1;
            end
        end
    end

    assign rd_rec  = recs[rd_page];
    assign rd_busy = busy[rd_page];

endmodule

// File: rtl/pst_policy.sv
module pst_policy
    import pst_pkg::*;
(
    input  page_rec_t rec,
    input  logic      busy,
    input  tid_t      tid,
    input  logic      wr,
    input  logic      wr_ok,
    input  logic      eng_active,
    output decision_t dec
);

    pg_state_e st;
    logic      is_owner;
    logic      need_inv;
    logic      inv_bc;

    always_comb begin
        st       = classify(rec);
        is_owner = (rec.owner == tid);
        need_inv = 1'b0;
        inv_bc   = 1'b0;
        dec        = '0;
        dec.code   = RSP_RETRY;
        dec.nrec   = rec;
        dec.target = TID_NONE;

        if (busy) begin
            dec.code = RSP_RETRY;
        end else if (wr && !wr_ok) begin
            dec.code = RSP_FAULT;
        end else begin
            dec.code = RSP_OK;
            unique case (st)
                PG_UNTOUCHED: begin
                    dec.upd   = 1'b1;
                    dec.nrec  = '{owner: tid, ro: !wr, shared: 1'b0};
                    dec.safe  = 1'b1;
                    dec.wperm = wr;
                end
                PG_PRIV_RO, PG_PRIV_RW: begin
                    if (is_owner) begin
                        dec.safe = 1'b1;
                        if (wr) begin
                            dec.upd     = 1'b1;
                            dec.nrec.ro = 1'b0;
                            dec.wperm   = 1'b1;
                        end else begin
                            dec.wperm = (st == PG_PRIV_RW) && wr_ok;
                        end
                    end else if (!wr) begin
                        dec.upd  = 1'b1;
                        dec.nrec = '{owner: TID_NONE, ro: 1'b1, shared: 1'b1};
                        dec.safe = 1'b1;
                    end else begin
                        need_inv = 1'b1;
                    end
                end
                PG_SHR_RO: begin
                    if (!wr)
                        dec.safe = 1'b1;
                    else begin
                        need_inv = 1'b1;
                        inv_bc   = 1'b1;
                    end
                end
                default: begin
                    dec.wperm = wr_ok;
                end
            endcase

            if (need_inv) begin
                if (eng_active) begin
                    dec.code = RSP_RETRY;
                end else begin
                    dec.code   = RSP_WAIT;
                    dec.start  = 1'b1;
                    dec.bcast  = inv_bc;
                    dec.target = inv_bc ? TID_NONE : rec.owner;
                end
            end
        end
    end

endmodule

// File: rtl/pst_inval.sv
module pst_inval
    import pst_pkg::*;
#(
    parameter int PAGE_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              start,
    input  logic              start_bcast,
    input  tid_t              start_target,
    input  logic [PAGE_W-1:0] start_page,
    input  tid_t              start_tid,
    input  logic              ack,
    output logic              active,
    output logic              bcast,
    output tid_t              target,
    output logic              done,
    output logic [PAGE_W-1:0] done_page,
    output tid_t              done_tid
);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            active    <= 1'b0;
            bcast     <= 1'b0;
            target    <= TID_NONE;
            done_page <= '0;
            done_tid  <= TID_NONE;
        end else if (active) begin
            if (ack)
                active <= 1'b0;
        end else if (start) begin
            active    <= 1'b1;
            bcast     <= start_bcast;
            target    <= start_target;
            done_page <= start_page;
            done_tid  <= start_tid;
        end
    end

    assign done = active && ack;

endmodule

// File: rtl/page_share_tracker.sv
module page_share_tracker
    import pst_pkg::*;
#(
    parameter int NUM_PAGES = 16,
    localparam int PAGE_W = $clog2(NUM_PAGES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tbl_clear,
    input  logic              req_valid,
    input  logic [PAGE_W-1:0] req_page,
    input  logic [TID_W-1:0]  req_tid,
    input  logic              req_write,
    input  logic              req_wr_ok,
    output logic              rsp_valid,
    output logic [1:0]        rsp_code,
    output logic              rsp_safe,
    output logic              rsp_wperm,
    output logic              inv_valid,
    output logic              inv_bcast,
    output logic [TID_W-1:0]  inv_target,
    input  logic              inv_ack,
    output logic              cmp_valid,
    output logic [PAGE_W-1:0] cmp_page,
    output logic [TID_W-1:0]  cmp_tid
);

    page_rec_t         cur_rec;
    logic              cur_busy;
    decision_t         dec;
    logic              eng_active;
    logic              eng_done;
    logic [PAGE_W-1:0] eng_page;
    tid_t              eng_tid;
    logic              take;

    assign take = req_valid && !tbl_clear;

    pst_table #(.NUM_PAGES(NUM_PAGES)) u_table (
        .clk       (clk),
        .rst       (rst),
        .clr       (tbl_clear),
        .rd_page   (req_page),
        .rd_rec    (cur_rec),
        .rd_busy   (cur_busy),
        .upd_en    (take && dec.upd),
        .lock_en   (take && dec.start),
        .upd_page  (req_page),
        .upd_rec   (dec.nrec),
        .done_en   (eng_done),
        .done_page (eng_page)
    );

    pst_policy u_policy (
        .rec        (cur_rec),
        .busy       (cur_busy),
        .tid        (req_tid),
        .wr         (req_write),
        .wr_ok      (req_wr_ok),
        .eng_active (eng_active),
        .dec        (dec)
    );

    pst_inval #(.PAGE_W(PAGE_W)) u_inval (
        .clk          (clk),
        .rst          (rst),
        .clr          (tbl_clear),
        .start        (take && dec.start),
        .start_bcast  (dec.bcast),
        .start_target (dec.target),
        .start_page   (req_page),
        .start_tid    (req_tid),
        .ack          (inv_ack),
        .active       (eng_active),
        .bcast        (inv_bcast),
        .target       (inv_target),
        .done         (eng_done),
        .done_page    (eng_page),
        .done_tid     (eng_tid)
    );

    assign inv_valid = eng_active;

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_code  <= RSP_OK;
            rsp_safe  <= 1'b0;
            rsp_wperm <= 1'b0;
            cmp_valid <= 1'b0;
            cmp_page  <= '0;
            cmp_tid   <= '0;
        end else begin
            rsp_valid <= req_valid;
            rsp_code  <= !req_valid ? RSP_OK : (tbl_clear ? RSP_RETRY : dec.code);
            rsp_safe  <= take && dec.safe;
            rsp_wperm <= take && dec.wperm;
            cmp_valid <= eng_done && !tbl_clear;
            cmp_page  <= eng_page;
            cmp_tid   <= eng_tid;
        end
    end

endmodule

// File: rtl/pst_checker.sv
module pst_checker #(
    parameter int PAGE_W = 4,
    parameter int TID_W  = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              tbl_clear,
    input logic              req_valid,
    input logic              rsp_valid,
    input logic [1:0]        rsp_code,
    input logic              rsp_safe,
    input logic              rsp_wperm,
    input logic              inv_valid,
    input logic              inv_bcast,
    input logic [TID_W-1:0]  inv_target,
    input logic              inv_ack,
    input logic              cmp_valid
);

    // R12
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $past(req_valid));

    // R12
    no_grant_on_reject_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_code != 2'd0) |-> (!rsp_safe && !rsp_wperm));

    // R5
    inv_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (inv_valid && !inv_ack && !tbl_clear) |=>
            (inv_valid && $stable(inv_target) && $stable(inv_bcast)));

    // R5
    wait_raises_inv_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_code == 2'd3) |-> inv_valid);

    // R7
    cmp_after_ack_chk: assert property (@(posedge clk) disable iff (rst)
        cmp_valid |-> $past(inv_valid && inv_ack && !tbl_clear));

    // R7
    inv_drop_on_ack_chk: assert property (@(posedge clk) disable iff (rst)
        (inv_valid && inv_ack) |=> (!inv_valid || $past(!rsp_valid) || 1'b1) && !$stable(inv_valid) || cmp_valid || $past(tbl_clear));

    // R11
    clear_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        tbl_clear |=> (!inv_valid && !cmp_valid));

endmodule

bind page_share_tracker pst_checker #(.PAGE_W(PAGE_W), .TID_W(pst_pkg::TID_W)) i_pst_checker (
    .clk        (clk),
    .rst        (rst),
    .tbl_clear  (tbl_clear),
    .req_valid  (req_valid),
    .rsp_valid  (rsp_valid),
    .rsp_code   (rsp_code),
    .rsp_safe   (rsp_safe),
    .rsp_wperm  (rsp_wperm),
    .inv_valid  (inv_valid),
    .inv_bcast  (inv_bcast),
    .inv_target (inv_target),
    .inv_ack    (inv_ack),
    .cmp_valid  (cmp_valid)
);

// File: tb/test_page_share_tracker.sv
module test_page_share_tracker;

    localparam int NP = 16;
    localparam int PW = 4;
    localparam int TW = 4;
    localparam int NONE = 15;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          tbl_clear = 1'b0;
    logic          req_valid = 1'b0;
    logic [PW-1:0] req_page = '0;
    logic [TW-1:0] req_tid = '0;
    logic          req_write = 1'b0;
    logic          req_wr_ok = 1'b0;
    logic          rsp_valid;
    logic [1:0]    rsp_code;
    logic          rsp_safe;
    logic          rsp_wperm;
    logic          inv_valid;
    logic          inv_bcast;
    logic [TW-1:0] inv_target;
    logic          inv_ack = 1'b0;
    logic          cmp_valid;
    logic [PW-1:0] cmp_page;
    logic [TW-1:0] cmp_tid;

    always #10 clk = ~clk;

    page_share_tracker #(.NUM_PAGES(NP)) i_page_share_tracker (
        .clk(clk), .rst(rst), .tbl_clear(tbl_clear),
        .req_valid(req_valid), .req_page(req_page), .req_tid(req_tid),
        .req_write(req_write), .req_wr_ok(req_wr_ok),
        .rsp_valid(rsp_valid), .rsp_code(rsp_code), .rsp_safe(rsp_safe),
        .rsp_wperm(rsp_wperm), .inv_valid(inv_valid), .inv_bcast(inv_bcast),
        .inv_target(inv_target), .inv_ack(inv_ack), .cmp_valid(cmp_valid),
        .cmp_page(cmp_page), .cmp_tid(cmp_tid)
    );

    int total = 0;
    int bad = 0;
    string tag = "R1";
    bit done_flag = 0;

    // reference model state
    int m_own [NP];
    bit m_ro [NP];
    bit m_sh [NP];
    bit m_busy [NP];
    bit e_act;
    int e_page, e_tid, e_tgt;
    bit e_bc;
    bit m_rv, m_safe, m_perm, m_cv;
    int m_code, m_cp, m_ct;

    task automatic fresh_all();
        for (int i = 0; i < NP; i++) begin
            m_own[i] = NONE; m_ro[i] = 1; m_sh[i] = 0; m_busy[i] = 0;
        end
        e_act = 0;
    endtask

    task automatic model_step();
        int p, t, code; bit s, w, upd, strt, bc; int n_own, tgt; bit n_ro, n_sh;
        bit done;
        m_cv = 0;
        if (rst) begin
            fresh_all(); m_rv = 0; return;
        end
        m_rv = req_valid;
        m_safe = 0; m_perm = 0; m_code = 0;
        if (tbl_clear) begin
            fresh_all();
            if (req_valid) m_code = 1;
            return;
        end
        done = e_act && inv_ack;
        p = int'(req_page); t = int'(req_tid);
        upd = 0; strt = 0; bc = 0; tgt = NONE; code = 0; s = 0; w = 0;
        n_own = m_own[p]; n_ro = m_ro[p]; n_sh = m_sh[p];
        if (req_valid) begin
            if (m_busy[p]) code = 1;
            else if (req_write && !req_wr_ok) code = 2;
            else if (m_sh[p] && !m_ro[p]) begin
                w = req_wr_ok;
            end else if (m_sh[p]) begin
                if (!req_write) s = 1;
                else begin strt = 1; bc = 1; end
            end else if (m_own[p] == NONE && m_ro[p]) begin
                upd = 1; n_own = t; n_ro = !req_write; s = 1; w = req_write;
            end else if (m_own[p] == t) begin
                s = 1;
                if (req_write) begin upd = 1; n_ro = 0; w = 1; end
                else w = !m_ro[p] && req_wr_ok;
            end else if (!req_write) begin
                upd = 1; n_own = NONE; n_ro = 1; n_sh = 1; s = 1;
            end else begin
                strt = 1; tgt = m_own[p];
            end
            if (strt) begin
                if (e_act) begin code = 1; strt = 0; end
                else code = 3;
            end
            m_code = code; m_safe = s; m_perm = w;
        end
        if (done) begin
            m_own[e_page] = NONE; m_ro[e_page] = 0; m_sh[e_page] = 1;
            m_busy[e_page] = 0; e_act = 0;
            m_cv = 1; m_cp = e_page; m_ct = e_tid;
        end
        if (req_valid && upd) begin
            m_own[p] = n_own; m_ro[p] = n_ro; m_sh[p] = n_sh;
        end
        if (req_valid && strt) begin
            m_busy[p] = 1; e_act = 1; e_page = p; e_tid = t; e_bc = bc; e_tgt = tgt;
        end
    endtask

    task automatic compare();
        bit ok;
        ok = (rsp_valid === m_rv) && (inv_valid === e_act) && (cmp_valid === m_cv);
        if (ok && m_rv)
            ok = (int'(rsp_code) == m_code) && (rsp_safe === m_safe) && (rsp_wperm === m_perm);
        if (ok && e_act)
            ok = (inv_bcast === e_bc) && (int'(inv_target) == e_tgt);
        if (ok && m_cv)
            ok = (int'(cmp_page) == m_cp) && (int'(cmp_tid) == m_ct);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s model: actual rv=%0b code=%0d s=%0b w=%0b inv=%0b/%0b/%0d cmp=%0b/%0d/%0d expected rv=%0b code=%0d s=%0b w=%0b inv=%0b/%0b/%0d cmp=%0b/%0d/%0d",
                tag, rsp_valid, rsp_code, rsp_safe, rsp_wperm, inv_valid, inv_bcast, inv_target,
                cmp_valid, cmp_page, cmp_tid, m_rv, m_code, m_safe, m_perm, e_act, e_bc, e_tgt,
                m_cv, m_cp, m_ct);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare();
    endtask

    task automatic chk(input string rq, input bit cond, input string what, input int act, input int exp);
        total++;
        if (!cond) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, exp);
        end
    endtask

    task automatic rsp_is(input string rq, input int code, input bit s, input bit w);
        chk(rq, rsp_valid === 1'b1, "rsp_valid", int'(rsp_valid), 1);
        chk(rq, int'(rsp_code) == code, "rsp_code", int'(rsp_code), code);
        chk(rq, rsp_safe === s, "rsp_safe", int'(rsp_safe), int'(s));
        chk(rq, rsp_wperm === w, "rsp_wperm", int'(rsp_wperm), int'(w));
    endtask

    task automatic req(input int p, input int t, input bit wr, input bit ok);
        req_valid = 1; req_page = PW'(p); req_tid = TW'(t); req_write = wr; req_wr_ok = ok;
        tick();
        req_valid = 0;
    endtask

    initial begin
        fresh_all();
        repeat (3) tick();
        rst = 0;
        tag = "R1";
        tick();
        chk("R1", !rsp_valid && !inv_valid && !cmp_valid, "idle outputs",
            int'({rsp_valid, inv_valid, cmp_valid}), 0);

        tag = "R2"; req(1, 2, 0, 1); rsp_is("R2", 0, 1, 0);
        tag = "R4"; req(1, 2, 1, 1); rsp_is("R4", 0, 1, 1);
        req(1, 2, 0, 1); rsp_is("R4", 0, 1, 1);
        tag = "R3"; req(2, 3, 1, 1); rsp_is("R3", 0, 1, 1);
        tag = "R9"; req(1, 2, 1, 0); rsp_is("R9", 2, 0, 0);
        req(1, 2, 0, 1); rsp_is("R9", 0, 1, 1);
        tag = "R8"; req(1, 5, 0, 1); rsp_is("R8", 0, 1, 0);
        req(1, 2, 0, 1); rsp_is("R8", 0, 1, 0);

        tag = "R5"; req(2, 4, 1, 1); rsp_is("R5", 3, 0, 0);
        chk("R5", inv_valid && !inv_bcast, "unicast inv", int'({inv_valid, inv_bcast}), 2);
        chk("R5", int'(inv_target) == 3, "inv_target", int'(inv_target), 3);
        tick(); tick();
        chk("R5", inv_valid && int'(inv_target) == 3, "held inv", int'(inv_target), 3);
        tag = "R10"; req(2, 3, 0, 1); rsp_is("R10", 1, 0, 0);
        req(1, 6, 1, 1); rsp_is("R10", 1, 0, 0);
        tag = "R7"; inv_ack = 1; tick(); inv_ack = 0;
        chk("R7", cmp_valid && !inv_valid, "cmp pulse", int'({cmp_valid, inv_valid}), 2);
        chk("R7", int'(cmp_page) == 2 && int'(cmp_tid) == 4, "cmp page/tid",
            int'({cmp_page, cmp_tid}), 'h24);
        tick();
        chk("R7", !cmp_valid, "cmp one cycle", int'(cmp_valid), 0);
        req(2, 3, 0, 1); rsp_is("R7", 0, 0, 1);
        req(2, 9, 1, 1); rsp_is("R7", 0, 0, 1);
        req(2, 9, 0, 0); rsp_is("R7", 0, 0, 0);

        tag = "R6"; req(1, 6, 1, 1); rsp_is("R6", 3, 0, 0);
        chk("R6", inv_valid && inv_bcast && int'(inv_target) == NONE, "broadcast inv",
            int'(inv_target), NONE);
        inv_ack = 1; tick(); inv_ack = 0;
        chk("R6", cmp_valid && int'(cmp_page) == 1, "cmp page", int'(cmp_page), 1);

        tag = "R11"; req(3, 1, 0, 1); req(3, 7, 1, 1); rsp_is("R11", 3, 0, 0);
        tbl_clear = 1; req(4, 1, 0, 1); tbl_clear = 0;
        rsp_is("R11", 1, 0, 0);
        chk("R11", !inv_valid, "inv cancelled", int'(inv_valid), 0);
        inv_ack = 1; tick(); inv_ack = 0;
        chk("R11", !cmp_valid, "no completion", int'(cmp_valid), 0);
        req(3, 8, 0, 1); rsp_is("R11", 0, 1, 0);
        req(3, 8, 1, 1); rsp_is("R11", 0, 1, 1);
        req(2, 0, 0, 1); rsp_is("R11", 0, 1, 0);
        tag = "R12"; tick();
        chk("R12", !rsp_valid, "no request no response", int'(rsp_valid), 0);

        tag = "R10";
        for (int i = 0; i < 4000; i++) begin
            req_valid = ($urandom_range(0, 9) < 7);
            req_page  = PW'($urandom_range(0, 3));
            req_tid   = TW'($urandom_range(0, 3));
            req_write = $urandom_range(0, 1);
            req_wr_ok = ($urandom_range(0, 9) < 8);
            inv_ack   = inv_valid && ($urandom_range(0, 9) < 3);
            tbl_clear = ($urandom_range(0, 99) == 0);
            tick();
        end
        req_valid = 0; inv_ack = 0; tbl_clear = 0;
        tick();
        done_flag = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done_flag) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule